// File: doc/BRIEF.md
# Multi-Channel Phase-Aligned PWM Generator

This block produces several pulse-width-modulated outputs from one clock. Software programs three values for each channel: how many cycles a period lasts, how many of those cycles the output is high, and how many cycles to wait before the first rising edge. New values go into holding registers. A channel only picks them up at an alignment event, so a period that is already running is never changed part way through.

An alignment event restarts every channel together. It comes from a falling edge on an external sync pin, after a two-flop synchronizer. Control bits choose how the event is handled:
- Automatic mode realigns on every falling edge. Armed mode realigns only when software has armed the block first.
- A forced realignment cuts the running pulses at once. A graceful one waits until the running periods end.
- After the event, the first pulse starts either immediately or one full period later.

A soft-reset bit holds the whole block idle. The reset values of all of these control bits are set by parameters.

Top module: `pwm_align_gen`

## Requirements
- R1: Register write address is `{channel, field}`, with the field in the two low bits: 0 = period, 1 = width, 2 = offset. Field 3 at channel 0 is the control word: bit0 soft reset, bit1 start-now, bit2 force, bit3 auto-sync, bit4 load/arm (acts only when written as 1, is not stored), bits 8 and up are the per-channel enables. After reset the control word holds the parameter defaults, all outputs are low, and every channel stays idle until its first alignment.
- R2: If `ext_sync` is first low in cycle c, the alignment happens at the rising edge that ends cycle c+2. Take A as the first cycle after that edge, P as the period, W as the width and D as the start delay. An aligned channel is then high in cycle X exactly when X-A >= D and (X-A-D) mod P < W.
- R3: With start-now set, D equals the programmed offset.
- R4: With start-now clear, D equals the offset plus one period.
- R5: A write to period, width or offset does not change a running waveform. The new value is used from the next alignment on.
- R6: With auto-sync clear, a sync falling edge is ignored unless load was written since the last trigger. After a load, the next falling edge realigns the channels and disarms the block.
- R7: With auto-sync set, every sync falling edge realigns the channels.
- R8: With force set, the realignment happens at once and cuts any active pulse. With force clear, it waits for the first cycle, from the trigger cycle on, in which every enabled channel that is already pulsing sits in the last cycle of its period. Channels still in their start delay do not hold it back. All channels then restart at the next edge.
- R9: Width 0 keeps the output low. A width equal to or greater than the period keeps it high, with no low cycle at the period wrap.
- R10: A disabled channel drives low starting the cycle after the enable bit is cleared.
- R11: While soft reset is set, all outputs are low, all channels are idle and sync edges are ignored. After release, the outputs stay low until the next alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Write address {channel, field} |
| cfg_wdata | input | DATA_W | Write data |
| ext_sync | input | 1 | External sync; a falling edge triggers alignment |
| pwm_out | output | N_CH | PWM outputs, one per channel |

## Verification
The hardest case to reach is a graceful realignment that has to wait, because two running channels with different periods must both reach the last cycle of their periods together. The stimulus first aligns channels with periods 4 and 6. It then clears force, stores a new offset and drops sync at an arbitrary point. The bench uses its own waveform model to predict the first common period end. It checks that the old waveform runs unchanged up to that cycle and that the new phase starts right after it. Armed-mode rejection is checked the same way: the old waveform must continue unchanged through a sync edge that has no load before it.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;

   typedef enum logic [1:0] {
      FLD_PERIOD = 2'd0,
      FLD_WIDTH  = 2'd1,
      FLD_OFFSET = 2'd2,
      FLD_CTRL   = 2'd3
   } fld_e;

   typedef struct packed {
      logic auto_sync;
      logic force_now;
      logic start_now;
      logic soft_rst;
   } opt_t;

   localparam int CTRL_SRST_BIT  = 0;
   localparam int CTRL_START_BIT = 1;
   localparam int CTRL_FORCE_BIT = 2;
   localparam int CTRL_AUTO_BIT  = 3;
   localparam int CTRL_LOAD_BIT  = 4;
   localparam int CTRL_EN_LSB    = 8;

endpackage

// File: rtl/pwm_align_regs.sv
module pwm_align_regs
   import pwm_align_pkg::*;
#(
   parameter int N_CH            = 3,
   parameter int CNT_W           = 16,
   parameter int DATA_W          = 32,
   parameter int CH_W            = 2,
   parameter bit DFLT_SOFT_RST   = 1'b0,
   parameter bit DFLT_START_NOW  = 1'b1,
   parameter bit DFLT_FORCE      = 1'b1,
   parameter bit DFLT_AUTO_SYNC  = 1'b1,
   parameter bit DFLT_EN         = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [CH_W+1:0]             wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   output opt_t                        opt,
   output logic [N_CH-1:0]             ch_en,
   output logic                        load_pulse,
   output logic [N_CH-1:0][CNT_W-1:0]  per_sh,
   output logic [N_CH-1:0][CNT_W-1:0]  wid_sh,
   output logic [N_CH-1:0][CNT_W-1:0]  off_sh
);

   fld_e            wr_fld;
   logic [CH_W-1:0] wr_ch;
   logic            ctrl_hit;

   assign wr_fld     = fld_e'(wr_addr[1:0]);
   assign wr_ch      = wr_addr[CH_W+1:2];
   assign ctrl_hit   = wr_en && (wr_fld == FLD_CTRL) && (wr_ch == '0);
   assign load_pulse = ctrl_hit && wr_data[CTRL_LOAD_BIT];

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opt.soft_rst  <= DFLT_SOFT_RST;
         opt.start_now <= DFLT_START_NOW;
         opt.force_now <= DFLT_FORCE;
         opt.auto_sync <= DFLT_AUTO_SYNC;
         ch_en         <= {N_CH{DFLT_EN}};
      end else if (ctrl_hit) begin
         opt.soft_rst  <= wr_data[CTRL_SRST_BIT];
         opt.start_now <= wr_data[CTRL_START_BIT];
         opt.force_now <= wr_data[CTRL_FORCE_BIT];
         opt.auto_sync <= wr_data[CTRL_AUTO_BIT];
         ch_en         <= wr_data[CTRL_EN_LSB +: N_CH];
      end
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_sh[i] <= '0;
            wid_sh[i] <= '0;
            off_sh[i] <= '0;
         end else if (wr_en && wr_ch == CH_W'(i)) begin
            case (wr_fld)
               FLD_PERIOD: per_sh[i] <= wr_data[CNT_W-1:0];
               FLD_WIDTH:  wid_sh[i] <= wr_data[CNT_W-1:0];
               FLD_OFFSET: off_sh[i] <= wr_data[CNT_W-1:0];
               default:    ;
            endcase
         end
      end
   end

endmodule

// File: rtl/pwm_align_trig.sv
module pwm_align_trig (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_sync,
   input  logic soft_rst,
   input  logic auto_sync,
   input  logic force_now,
   input  logic load_pulse,
   input  logic all_done,
   output logic align_o
);

   logic sync_q1, sync_q2, sync_q3;
   logic armed, pending;
   logic fall, trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q1 <= 1'b1;
         sync_q2 <= 1'b1;
         sync_q3 <= 1'b1;
      end else begin
         sync_q1 <= ext_sync;
         sync_q2 <= sync_q1;
         sync_q3 <= sync_q2;
      end
   end

   assign fall    = sync_q3 && !sync_q2;
   assign trig    = !soft_rst && fall && (auto_sync || armed);
   assign align_o = !soft_rst &&
                    (force_now ? trig : ((trig || pending) && all_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         pending <= 1'b0;
      end else if (soft_rst) begin
         armed   <= 1'b0;
         pending <= 1'b0;
      end else begin
         armed   <= load_pulse || (armed && !trig);
         pending <= !force_now && (pending || trig) && !align_o;
      end
   end

   // R6: without auto-sync and without an arm, nothing may align
   assert_armed_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_sync && !armed && !pending) |-> !align_o);

   // R8: a forced alignment only happens on a detected sync falling edge
   assert_force_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (force_now && align_o) |-> (sync_q3 && !sync_q2));

   // R8: a waiting request is consumed by the alignment
   assert_pending_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      align_o |=> !pending);

   // R11: soft reset blocks alignment
   assert_srst_no_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> !align_o);

endmodule

// File: rtl/pwm_align_channel.sv
module pwm_align_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             align,
   input  logic             start_now,
   input  logic             en,
   input  logic [CNT_W-1:0] per_sh,
   input  logic [CNT_W-1:0] wid_sh,
   input  logic [CNT_W-1:0] off_sh,
   output logic             pwm,
   output logic             done
);

   localparam int DLY_W = CNT_W + 1;

   logic             active;
   logic [CNT_W-1:0] per_a, wid_a, cnt;
   logic [DLY_W-1:0] dly;
   logic             last;

   assign last = (cnt == per_a - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         per_a  <= '0;
         wid_a  <= '0;
         cnt    <= '0;
         dly    <= '0;
      end else if (soft_rst) begin
         active <= 1'b0;
         cnt    <= '0;
         dly    <= '0;
      end else if (align) begin
         active <= (per_sh != '0);
         per_a  <= per_sh;
         wid_a  <= wid_sh;
         cnt    <= '0;
         dly    <= {1'b0, off_sh} + (start_now ? '0 : {1'b0, per_sh});
      end else if (active) begin
         if (dly != '0) dly <= dly - 1'b1;
         else           cnt <= last ? '0 : cnt + 1'b1;
      end
   end

   assign pwm  = en && active && (dly == '0) && (cnt < wid_a);
   assign done = !en || !active || (dly != '0) || last;

   // R2: the phase counter stays inside the period
   assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt < per_a));

   // R9: zero width never drives high
   assert_zero_width_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wid_a == '0) |-> !pwm);

   // R9: full width stays high across the wrap
   assert_full_duty_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && active && dly == '0 && wid_a >= per_a) |-> pwm);

   // R10: disabled channel is low
   assert_disabled_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pwm);

   // R5: the live settings only move at an alignment
   assert_hold_settings_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!align) |=> ($stable(per_a) && $stable(wid_a)));

   // R11: soft reset idles the channel
   assert_srst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!active && !pwm));

endmodule

// File: rtl/pwm_align_gen.sv
module pwm_align_gen
   import pwm_align_pkg::*;
#(
   parameter int N_CH           = 3,
   parameter int CNT_W          = 16,
   parameter int DATA_W         = 32,
   parameter bit DFLT_SOFT_RST  = 1'b0,
   parameter bit DFLT_START_NOW = 1'b1,
   parameter bit DFLT_FORCE     = 1'b1,
   parameter bit DFLT_AUTO_SYNC = 1'b1,
   parameter bit DFLT_EN        = 1'b1,
   localparam int CH_W          = (N_CH > 1) ? $clog2(N_CH) : 1,
   localparam int ADDR_W        = CH_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              ext_sync,
   output logic [N_CH-1:0]   pwm_out
);

   if (N_CH < 1 || N_CH > DATA_W - CTRL_EN_LSB) begin : g_bad_nch
      $error("pwm_align_gen: N_CH out of range");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cntw
      $error("pwm_align_gen: CNT_W out of range");
   end

   opt_t                       opt;
   logic [N_CH-1:0]            ch_en;
   logic                       load_pulse;
   logic [N_CH-1:0][CNT_W-1:0] per_sh, wid_sh, off_sh;
   logic [N_CH-1:0]            done;
   logic                       align;

   pwm_align_regs #(
      .N_CH(N_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .CH_W(CH_W),
      .DFLT_SOFT_RST(DFLT_SOFT_RST), .DFLT_START_NOW(DFLT_START_NOW),
      .DFLT_FORCE(DFLT_FORCE), .DFLT_AUTO_SYNC(DFLT_AUTO_SYNC),
      .DFLT_EN(DFLT_EN)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr),
      .wr_data(cfg_wdata), .opt(opt), .ch_en(ch_en), .load_pulse(load_pulse),
      .per_sh(per_sh), .wid_sh(wid_sh), .off_sh(off_sh)
   );

   pwm_align_trig i_trig (
      .clk(clk), .rst_n(rst_n), .ext_sync(ext_sync), .soft_rst(opt.soft_rst),
      .auto_sync(opt.auto_sync), .force_now(opt.force_now),
      .load_pulse(load_pulse), .all_done(&done), .align_o(align)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      pwm_align_channel #(.CNT_W(CNT_W)) i_ch (
         .clk(clk), .rst_n(rst_n), .soft_rst(opt.soft_rst), .align(align),
         .start_now(opt.start_now), .en(ch_en[i]), .per_sh(per_sh[i]),
         .wid_sh(wid_sh[i]), .off_sh(off_sh[i]), .pwm(pwm_out[i]),
         .done(done[i])
      );
   end

   // R11: outputs are all low the cycle after soft reset is seen
   assert_srst_outputs_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      opt.soft_rst |=> (pwm_out == '0));

endmodule

// File: tb/test_pwm_align_gen.sv
`timescale 1ns/1ps
module test_pwm_align_gen;
   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cfg_wr;
   logic [3:0]   cfg_addr;
   logic [31:0]  cfg_wdata;
   logic         ext_sync;
   logic [N-1:0] pwm_out;

   always #2.5 clk = ~clk;

   pwm_align_gen i_pwm_align_gen (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .ext_sync(ext_sync), .pwm_out(pwm_out)
   );

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   int           q_cyc[$];
   logic [N-1:0] q_v[$];
   string        q_tag[$];

   int mA[N], mD[N], mP[N], mW[N];
   bit mEn[N], mAct[N];
   int shP[N], shW[N], shO[N];
   bit mStart;

   always @(posedge clk) cyc++;

   // monitor: pops expected items when their cycle arrives
   always @(negedge clk) begin
      while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
         checks++;
         if (q_cyc[0] != cyc || pwm_out !== q_v[0]) begin
            errors++;
            $display("FAIL %s cycle %0d (due %0d): pwm_out=%b expected %b",
                     q_tag[0], cyc, q_cyc[0], pwm_out, q_v[0]);
         end
         void'(q_cyc.pop_front());
         void'(q_v.pop_front());
         void'(q_tag.pop_front());
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [N-1:0] exp_vec(int x);
      logic [N-1:0] v = '0;
      for (int i = 0; i < N; i++) begin
         if (mEn[i] && mAct[i] && (x - mA[i]) >= mD[i])
            v[i] = (((x - mA[i] - mD[i]) % mP[i]) < mW[i]);
      end
      return v;
   endfunction

   function automatic bit all_done(int x);
      for (int i = 0; i < N; i++) begin
         if (mEn[i] && mAct[i] && (x - mA[i]) >= mD[i] &&
             ((x - mA[i] - mD[i]) % mP[i]) != mP[i] - 1)
            return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic push_range(int from, int to, string tag);
      for (int x = from; x <= to; x++) begin
         q_cyc.push_back(x);
         q_v.push_back(exp_vec(x));
         q_tag.push_back(tag);
      end
   endtask

   task automatic drain();
      wait (q_cyc.size() == 0);
      @(negedge clk);
   endtask

   task automatic align_model(int a);
      for (int i = 0; i < N; i++) begin
         mA[i]   = a;
         mP[i]   = shP[i];
         mW[i]   = shW[i];
         mD[i]   = shO[i] + (mStart ? 0 : shP[i]);
         mAct[i] = (shP[i] != 0);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // address {channel[1:0], field[1:0]}: 0 period, 1 width, 2 offset (R1)
   task automatic set_ch(int ch, int p, int w, int o);
      wr({2'(ch), 2'd0}, 32'(p));
      wr({2'(ch), 2'd1}, 32'(w));
      wr({2'(ch), 2'd2}, 32'(o));
      shP[ch] = p; shW[ch] = w; shO[ch] = o;
   endtask

   // control word at address 3 (R1)
   task automatic set_ctrl(bit srst, bit start, bit frc, bit auto_s, bit load,
                           logic [2:0] en);
      wr(4'd3, {21'd0, en, 3'd0, load, auto_s, frc, start, srst});
      mStart = start;
      for (int i = 0; i < N; i++) mEn[i] = en[i];
      if (srst) for (int i = 0; i < N; i++) mAct[i] = 1'b0;
   endtask

   task automatic sync_fall(output int c);
      @(negedge clk);
      ext_sync = 1'b0;
      c = cyc;
   endtask

   task automatic sync_rise();
      @(negedge clk);
      ext_sync = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // forced alignment: old waveform until c+2, new from c+3
   task automatic forced_align(int len, string tag);
      int c;
      sync_fall(c);
      push_range(c + 1, c + 2, tag);
      align_model(c + 3);
      push_range(c + 3, c + 3 + len, tag);
      drain();
      sync_rise();
   endtask

   initial begin
      int c, y;
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; ext_sync = 1'b1;
      mStart = 1'b1;
      for (int i = 0; i < N; i++) begin
         mEn[i] = 1'b1; mAct[i] = 1'b0; mA[i] = 0; mD[i] = 0; mP[i] = 1; mW[i] = 0;
         shP[i] = 0; shW[i] = 0; shO[i] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, outputs low and idle
      push_range(cyc + 1, cyc + 8, "R1");
      drain();

      // R2 R3 R9: default control (start-now, force, auto), mixed widths
      set_ch(0, 6, 2, 1);
      set_ch(1, 4, 0, 0);
      set_ch(2, 5, 5, 2);
      push_range(cyc + 1, cyc + 6, "R1");   // shadow writes alone keep idle
      drain();
      forced_align(40, "R2/R3/R9");

      // R5: shadow write does not disturb running waveform
      set_ch(0, 6, 4, 0);
      push_range(cyc + 1, cyc + 24, "R5");
      drain();

      // R7: automatic mode realigns on each edge, new values now used
      forced_align(30, "R7");
      forced_align(20, "R7");

      // R4: start-now clear delays first pulse by one period
      set_ctrl(0, 0, 1, 1, 0, 3'b111);
      forced_align(40, "R4");

      // R6: armed mode ignores an unarmed edge
      set_ctrl(0, 1, 1, 0, 0, 3'b111);
      sync_fall(c);
      push_range(c + 1, c + 30, "R6");
      drain();
      sync_rise();
      set_ctrl(0, 1, 1, 0, 1, 3'b111);
      forced_align(30, "R6");
      sync_fall(c);
      push_range(c + 1, c + 20, "R6");
      drain();
      sync_rise();

      // R8: graceful wait for common end of running periods
      set_ctrl(0, 1, 1, 1, 0, 3'b011);
      set_ch(0, 4, 2, 0);
      set_ch(1, 6, 3, 0);
      forced_align(20, "R8");
      set_ch(0, 4, 2, 1);
      set_ctrl(0, 1, 0, 1, 0, 3'b011);
      sync_fall(c);
      y = c + 2;
      while (!all_done(y)) y++;
      push_range(c + 1, y, "R8");
      align_model(y + 1);
      push_range(y + 1, y + 30, "R8/R10");
      drain();
      sync_rise();

      // R10: disabling a channel forces it low
      set_ctrl(0, 1, 1, 1, 0, 3'b010);
      push_range(cyc + 1, cyc + 20, "R10");
      drain();

      // R11: soft reset idles everything and ignores sync
      set_ctrl(1, 1, 1, 1, 0, 3'b111);
      push_range(cyc + 1, cyc + 10, "R11");
      drain();
      sync_fall(c);
      push_range(c + 1, c + 12, "R11");
      drain();
      sync_rise();
      set_ctrl(0, 1, 1, 1, 0, 3'b111);
      push_range(cyc + 1, cyc + 10, "R11");
      drain();
      forced_align(20, "R11");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule